// File: doc/BRIEF.md
# SMBus Bus Timeout Detector

This block watches the clock and data lines of an I2C/SMBus port, after they have been brought into the kernel clock domain. It raises a sticky flag when a bus timeout occurs. Timer A has two modes, picked by a mode bit. In the first it measures how long the clock line stays low in one stretch. In the second it measures how long both lines stay high, which means the bus is idle. Timer B adds up, over one transfer, the clock-low cycles that the protocol engine marks as clock extension. It counts the master's extension in master mode and the slave's extension in slave mode. Timer B restarts at every START and STOP condition.

Software sets the block up through a 32-bit control word. A write is held for a fixed number of cycles before it takes effect. A second write that arrives during that time is stalled. A timer's duration field and its mode bit can only change while that timer's enable is clear. Each flag is cleared by a one-cycle clear pulse.

Top module: `smbus_timeout_monitor`

## Requirements
- R1: With timer A enabled and mode bit 0, `timeout_o` sets after the clock line has been sampled low for (A+1)×2048 consecutive cycles, where A is the timer-A duration field. A high sample on the clock line restarts the count.
- R2: With timer A enabled and mode bit 1, `idle_o` sets after both lines have been sampled high for (A+1)×4 consecutive cycles. A low sample on either line restarts the count.
- R3: While the timer-A enable (bit 15) is 1, writes leave the timer-A duration field (bits 11:0) and the mode bit (bit 12) unchanged. The enable bit itself still takes the written value.
- R4: With timer B enabled, `timeout_o` sets once (B+1)×2048 extension cycles have been counted in total, where B is the timer-B duration field. A cycle counts when the clock line is low and the selected extension input is 1. High clock phases pause the total but do not clear it.
- R5: When `master_i` is 1, timer B counts cycles marked by `mst_ext_i`. When `master_i` is 0, it counts cycles marked by `slv_ext_i`. The other input has no effect.
- R6: The timer-B total clears on a START condition (data falls while clock is high) and on a STOP condition (data rises while clock is high).
- R7: An accepted write takes effect 3 cycles after the edge that accepted it. `wr_rdy_o` is 0 from that edge until the write takes effect. A write presented in that time waits, and is then applied after the earlier one.
- R8: `timeout_o` and `idle_o` stay set until a one-cycle pulse on `clr_timeout_i` or `clr_idle_i`. After that pulse they read 0 on the next cycle.
- R9: Clearing a timer's enable resets its count. After it is enabled again, the full duration is needed before the flag sets.
- R10: `rd_data_o` returns the control word in this layout: timer-A duration in bits 11:0, mode bit in bit 12, timer-A enable in bit 15, timer-B duration in bits 27:16, timer-B enable in bit 31. All other bits read 0.
- R11: While the timer-B enable (bit 31) is 1, writes leave the timer-B duration field (bits 27:16) unchanged.
- R12: After reset, `rd_data_o` is 0, both flags are 0 and `wr_rdy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Clock line level, already synchronized |
| sda_i | input | 1 | Data line level, already synchronized |
| master_i | input | 1 | 1 when the controller acts as master |
| mst_ext_i | input | 1 | Marks the current clock-low cycle as master extension |
| slv_ext_i | input | 1 | Marks the current clock-low cycle as slave extension |
| wr_en_i | input | 1 | Control word write request |
| wr_data_i | input | 32 | Control word write data |
| wr_rdy_o | output | 1 | Write can be accepted this cycle |
| rd_data_o | output | 32 | Current control word |
| clr_timeout_i | input | 1 | Clear pulse for the timeout flag |
| clr_idle_i | input | 1 | Clear pulse for the idle flag |
| timeout_o | output | 1 | Sticky flag for a clock-low or extension timeout |
| idle_o | output | 1 | Sticky flag for bus idle detected |

## Verification
The hardest case to reach is showing that a count was really discarded. A discarded count leaves no trace at the ports until the full duration has passed again. To show it, the stimulus holds the clock line low for most of a period. It then briefly breaks the condition: a high clock pulse for timer A, a START for timer B, or a disable and re-enable through the write path with its latency. It then checks that the flag is still clear one cycle before a complete fresh period and set exactly at it. The same kind of exact-edge check shows that master mode ignores slave extension marks, that writes made while a timer is enabled leave its fields unchanged, and that a stalled write is applied only after the earlier one.

// File: rtl/smbto_pkg.sv
package smbto_pkg;

  localparam int unsigned REG_W    = 32;
  localparam int unsigned FIELD_W  = 12;
  localparam int unsigned TA_LSB   = 0;
  localparam int unsigned MODE_BIT = 12;
  localparam int unsigned ENA_BIT  = 15;
  localparam int unsigned TB_LSB   = 16;
  localparam int unsigned ENB_BIT  = 31;

  typedef struct packed {
    logic               en_b;
    logic [FIELD_W-1:0] dur_b;
    logic               en_a;
    logic               idle_mode;
    logic [FIELD_W-1:0] dur_a;
  } tmo_cfg_t;

  function automatic logic [REG_W-1:0] cfg_to_word(tmo_cfg_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[TA_LSB +: FIELD_W] = c.dur_a;
    w[MODE_BIT]          = c.idle_mode;
    w[ENA_BIT]           = c.en_a;
    w[TB_LSB +: FIELD_W] = c.dur_b;
    w[ENB_BIT]           = c.en_b;
    return w;
  endfunction

endpackage

// File: rtl/smbto_cfg_regs.sv
module smbto_cfg_regs
  import smbto_pkg::*;
#(
  parameter int unsigned WR_LAT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic             wr_rdy_o,
  output tmo_cfg_t         cfg_o,
  output logic [REG_W-1:0] rd_data_o
);

  localparam int unsigned LAT_W = (WR_LAT > 1) ? $clog2(WR_LAT) : 1;
  localparam logic [LAT_W-1:0] LAT_LAST = LAT_W'(WR_LAT - 1);

  logic             busy_q, busy_d;
  logic [LAT_W-1:0] lat_q, lat_d;
  logic [REG_W-1:0] pend_q, pend_d;
  tmo_cfg_t         cfg_q, cfg_d;
  logic             accept, apply;

  always_comb begin
    accept = wr_en_i && !busy_q;
    apply  = busy_q && (lat_q == LAT_LAST);
    busy_d = busy_q;
    lat_d  = lat_q;
    pend_d = pend_q;
    cfg_d  = cfg_q;
    if (accept) begin
      busy_d = 1'b1;
      lat_d  = '0;
      pend_d = wr_data_i;
    end else if (busy_q) begin
      if (apply) busy_d = 1'b0;
      else       lat_d  = lat_q + 1'b1;
    end
    if (apply) begin
      cfg_d.en_a = pend_q[ENA_BIT];
      cfg_d.en_b = pend_q[ENB_BIT];
      if (!cfg_q.en_a) begin
        cfg_d.dur_a     = pend_q[TA_LSB +: FIELD_W];
        cfg_d.idle_mode = pend_q[MODE_BIT];
      end
      if (!cfg_q.en_b) begin
        cfg_d.dur_b = pend_q[TB_LSB +: FIELD_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      lat_q  <= '0;
      pend_q <= '0;
      cfg_q  <= '0;
    end else begin
      busy_q <= busy_d;
      lat_q  <= lat_d;
      if (accept) pend_q <= pend_d;
      if (apply)  cfg_q  <= cfg_d;
    end
  end

  logic unused_gap_bits;
  assign unused_gap_bits = ^{pend_q[ENA_BIT-1:MODE_BIT+1], pend_q[ENB_BIT-1:TB_LSB+FIELD_W]};

  assign wr_rdy_o  = !busy_q;
  assign cfg_o     = cfg_q;
  assign rd_data_o = cfg_to_word(cfg_q);

  AST_DUR_A_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_q.en_a) |-> ($stable(cfg_q.dur_a) && $stable(cfg_q.idle_mode))); // R3

  AST_DUR_B_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_q.en_b) |-> $stable(cfg_q.dur_b)); // R11

  AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_rdy_o && wr_en_i) |=> $stable(pend_q)); // R7

endmodule

// File: rtl/smbto_line_watch.sv
module smbto_line_watch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    start_o = scl_q && scl_i && sda_q && !sda_i;
    stop_o  = scl_q && scl_i && !sda_q && sda_i;
  end

endmodule

// File: rtl/smbto_pcnt.sv
module smbto_pcnt #(
  parameter int unsigned PRE_W  = 11,
  parameter int unsigned UNIT_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cnt_en_i,
  input  logic [PRE_W-1:0]  pre_last_i,
  input  logic [UNIT_W-1:0] limit_i,
  output logic              hit_o
);

  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [UNIT_W-1:0] unit_q, unit_d;
  logic              done_q, done_d;
  logic              step, pre_wrap;

  always_comb begin
    step     = cnt_en_i && !done_q;
    pre_wrap = (pre_q == pre_last_i);
    hit_o    = step && pre_wrap && (unit_q == limit_i);
    pre_d    = pre_q;
    unit_d   = unit_q;
    done_d   = done_q;
    if (clr_i) begin
      pre_d  = '0;
      unit_d = '0;
      done_d = 1'b0;
    end else if (step) begin
      if (pre_wrap) begin
        pre_d = '0;
        if (unit_q == limit_i) done_d = 1'b1;
        else                   unit_d = unit_q + 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      unit_q <= '0;
      done_q <= 1'b0;
    end else if (clr_i || step) begin
      pre_q  <= pre_d;
      unit_q <= unit_d;
      done_q <= done_d;
    end
  end

  AST_UNIT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_q <= limit_i); // R1

  AST_PRE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= pre_last_i); // R2

endmodule

// File: rtl/smbus_timeout_monitor.sv
module smbus_timeout_monitor
  import smbto_pkg::*;
#(
  parameter int unsigned LOW_SHIFT  = 11,
  parameter int unsigned IDLE_SHIFT = 2,
  parameter int unsigned WR_LAT     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             master_i,
  input  logic             mst_ext_i,
  input  logic             slv_ext_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic             wr_rdy_o,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             clr_timeout_i,
  input  logic             clr_idle_i,
  output logic             timeout_o,
  output logic             idle_o
);

  localparam logic [LOW_SHIFT-1:0] LOW_LAST  = LOW_SHIFT'((1 << LOW_SHIFT) - 1);
  localparam logic [LOW_SHIFT-1:0] IDLE_LAST = LOW_SHIFT'((1 << IDLE_SHIFT) - 1);

  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  tmo_cfg_t cfg;

  smbto_cfg_regs #(.WR_LAT(WR_LAT)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .wr_rdy_o (wr_rdy_o),
    .cfg_o    (cfg),
    .rd_data_o(rd_data_o)
  );

  logic start_seen, stop_seen;

  smbto_line_watch u_watch (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .start_o(start_seen),
    .stop_o (stop_seen)
  );

  logic                 a_cond, a_en, a_clr, a_hit;
  logic [LOW_SHIFT-1:0] a_pre_last;
  logic                 b_mark, b_en, b_clr, b_hit;

  always_comb begin
    a_cond     = cfg.idle_mode ? (scl_i && sda_i) : !scl_i;
    a_en       = cfg.en_a && a_cond;
    a_clr      = !a_en;
    a_pre_last = cfg.idle_mode ? IDLE_LAST : LOW_LAST;
    b_mark     = master_i ? mst_ext_i : slv_ext_i;
    b_en       = cfg.en_b && !scl_i && b_mark;
    b_clr      = !cfg.en_b || start_seen || stop_seen;
  end

  smbto_pcnt #(.PRE_W(LOW_SHIFT), .UNIT_W(FIELD_W)) u_tmr_a (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .clr_i     (a_clr),
    .cnt_en_i  (a_en),
    .pre_last_i(a_pre_last),
    .limit_i   (cfg.dur_a),
    .hit_o     (a_hit)
  );

  smbto_pcnt #(.PRE_W(LOW_SHIFT), .UNIT_W(FIELD_W)) u_tmr_b (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .clr_i     (b_clr),
    .cnt_en_i  (b_en),
    .pre_last_i(LOW_LAST),
    .limit_i   (cfg.dur_b),
    .hit_o     (b_hit)
  );

  logic tmo_q, tmo_d, idle_q, idle_d;

  always_comb begin
    tmo_d  = (tmo_q && !clr_timeout_i) || b_hit || (a_hit && !cfg.idle_mode);
    idle_d = (idle_q && !clr_idle_i) || (a_hit && cfg.idle_mode);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q  <= 1'b0;
      idle_q <= 1'b0;
    end else begin
      tmo_q  <= tmo_d;
      idle_q <= idle_d;
    end
  end

  assign timeout_o = tmo_q;
  assign idle_o    = idle_q;

  AST_TMO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n)
    (timeout_o && !clr_timeout_i) |=> timeout_o); // R8

  AST_IDLE_NEEDS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(idle_o) |-> $past(scl_i && sda_i)); // R2

  AST_B_ONLY_LOW: assert property (@(posedge clk_i) disable iff (!rst_n)
    b_hit |-> (!scl_i && cfg.en_b)); // R4

endmodule

// File: tb/smbus_timeout_monitor_test.sv
module smbus_timeout_monitor_test;

  localparam int unsigned LAT = 3;

  logic        clk, rst_ni, scl, sda, master, mst_ext, slv_ext;
  logic        wr_en, clr_tmo, clr_idle;
  logic [31:0] wr_data;
  logic        wr_rdy, tmo, idle;
  logic [31:0] rd_data;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  smbus_timeout_monitor #(.WR_LAT(LAT)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda),
    .master_i(master), .mst_ext_i(mst_ext), .slv_ext_i(slv_ext),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .wr_rdy_o(wr_rdy), .rd_data_o(rd_data),
    .clr_timeout_i(clr_tmo), .clr_idle_i(clr_idle),
    .timeout_o(tmo), .idle_o(idle)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_issue(input logic [31:0] d);
    wr_en = 1'b1;
    wr_data = d;
    while (!wr_rdy) @(negedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d);
    wr_issue(d);
    repeat (LAT) @(negedge clk);
  endtask

  task automatic cfg_set(input logic [31:0] d);
    wr(32'h0);
    wr(d);
  endtask

  task automatic pulse_clr_tmo();
    clr_tmo = 1'b1; @(negedge clk); clr_tmo = 1'b0;
  endtask

  task automatic pulse_clr_idle();
    clr_idle = 1'b1; @(negedge clk); clr_idle = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 rd_data", rd_data, 32'h0);
    chk("R12 timeout", 32'(tmo), 32'h0);
    chk("R12 idle", 32'(idle), 32'h0);
    chk("R12 wr_rdy", 32'(wr_rdy), 32'h1);
  endtask

  task automatic t_layout();
    wr(32'hFFFF_FFFF);
    chk("R10 layout all ones", rd_data, 32'h8FFF_9FFF);
    wr(32'h0);
    chk("R3 R11 fields locked while enabled", rd_data, 32'h0FFF_1FFF);
    wr(32'h0);
    chk("R10 cleared word", rd_data, 32'h0);
  endtask

  task automatic t_stall();
    wr_issue(32'h0000_0123);
    chk("R7 busy after accept", 32'(wr_rdy), 32'h0);
    wr_en = 1'b1;
    wr_data = 32'h0456_0000;
    repeat (LAT - 1) @(negedge clk);
    chk("R7 not yet applied", rd_data, 32'h0);
    @(negedge clk);
    chk("R7 first write applied", rd_data, 32'h0000_0123);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R7 second write stalled", rd_data, 32'h0000_0123);
    repeat (LAT) @(negedge clk);
    chk("R7 second write applied", rd_data, 32'h0456_0000);
  endtask

  task automatic t_low_timeout();
    cfg_set(32'h0000_8000);
    scl = 1'b0;
    repeat (2000) @(negedge clk);
    scl = 1'b1; @(negedge clk); scl = 1'b0;
    repeat (2047) @(negedge clk);
    chk("R1 one cycle short after restart", 32'(tmo), 32'h0);
    @(negedge clk);
    chk("R1 clock-low timeout", 32'(tmo), 32'h1);
    chk("R1 idle flag untouched", 32'(idle), 32'h0);
  endtask

  task automatic t_sticky();
    scl = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 flag sticky", 32'(tmo), 32'h1);
    pulse_clr_tmo();
    chk("R8 flag cleared", 32'(tmo), 32'h0);
  endtask

  task automatic t_disable();
    cfg_set(32'h0000_8000);
    scl = 1'b0;
    repeat (2000) @(negedge clk);
    wr(32'h0);
    chk("R9 no timeout yet", 32'(tmo), 32'h0);
    wr(32'h0000_8000);
    repeat (2047) @(negedge clk);
    chk("R9 count restarted", 32'(tmo), 32'h0);
    @(negedge clk);
    chk("R9 full period after re-enable", 32'(tmo), 32'h1);
    scl = 1'b1;
    pulse_clr_tmo();
  endtask

  task automatic t_idle();
    sda = 1'b0;
    cfg_set(32'h0000_9002);
    sda = 1'b1;
    repeat (10) @(negedge clk);
    sda = 1'b0; @(negedge clk); sda = 1'b1;
    repeat (11) @(negedge clk);
    chk("R2 idle one short", 32'(idle), 32'h0);
    @(negedge clk);
    chk("R2 idle detected", 32'(idle), 32'h1);
    chk("R2 timeout untouched", 32'(tmo), 32'h0);
    pulse_clr_idle();
    chk("R8 idle cleared", 32'(idle), 32'h0);
  endtask

  task automatic t_lock_a();
    wr(32'h0000_8005);
    chk("R3 duration and mode kept", rd_data, 32'h0000_9002);
    sda = 1'b0; @(negedge clk); sda = 1'b1;
    repeat (11) @(negedge clk);
    chk("R3 old duration still one short", 32'(idle), 32'h0);
    @(negedge clk);
    chk("R3 old duration in effect", 32'(idle), 32'h1);
    pulse_clr_idle();
  endtask

  task automatic stop_cond();
    scl = 1'b1; @(negedge clk);
    sda = 1'b0; @(negedge clk);
    sda = 1'b1; @(negedge clk);
  endtask

  task automatic t_ext();
    cfg_set(32'h8000_0000);
    master = 1'b1; mst_ext = 1'b1; slv_ext = 1'b0;
    scl = 1'b0;
    repeat (1000) @(negedge clk);
    scl = 1'b1;
    repeat (10) @(negedge clk);
    scl = 1'b0;
    repeat (1047) @(negedge clk);
    chk("R4 total one short", 32'(tmo), 32'h0);
    @(negedge clk);
    chk("R4 extension timeout", 32'(tmo), 32'h1);
    scl = 1'b1;
    pulse_clr_tmo();
    stop_cond();
    master = 1'b0;
    scl = 1'b0;
    repeat (2100) @(negedge clk);
    chk("R5 master marks ignored in slave mode", 32'(tmo), 32'h0);
    slv_ext = 1'b1;
    repeat (2047) @(negedge clk);
    chk("R5 slave total one short", 32'(tmo), 32'h0);
    @(negedge clk);
    chk("R5 slave extension timeout", 32'(tmo), 32'h1);
    scl = 1'b1;
    pulse_clr_tmo();
    stop_cond();
    slv_ext = 1'b0;
    master = 1'b1;
    scl = 1'b0;
    repeat (1500) @(negedge clk);
    scl = 1'b1; @(negedge clk);
    sda = 1'b0; @(negedge clk);
    scl = 1'b0;
    repeat (2047) @(negedge clk);
    chk("R6 total cleared by START", 32'(tmo), 32'h0);
    @(negedge clk);
    chk("R6 full period after START", 32'(tmo), 32'h1);
    scl = 1'b1; @(negedge clk);
    sda = 1'b1; @(negedge clk);
    pulse_clr_tmo();
    wr(32'h8005_0000);
    chk("R11 timer-B duration kept", rd_data, 32'h8000_0000);
  endtask

  initial begin
    rst_ni = 1'b0; scl = 1'b1; sda = 1'b1;
    master = 1'b1; mst_ext = 1'b0; slv_ext = 1'b0;
    wr_en = 1'b0; wr_data = 32'h0; clr_tmo = 1'b0; clr_idle = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_layout();
    t_stall();
    t_low_timeout();
    t_sticky();
    t_disable();
    t_idle();
    t_lock_a();
    t_ext();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++;
      nerr++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule